// File: doc/BRIEF.md
# Timer/counter with match and capture channels

This block is a 32-bit timer/counter for a peripheral bus. A plain register port (write strobe, address, write data, combinational read data) configures it and reads its state back. The counter advances either on ticks from a programmable prescaler or on chosen edges of one of the capture pins. Four match channels compare the counter against their own values; on a hit each one can flag an interrupt, return the counter to zero, stop it, and act on its own match output pin. Two capture channels copy the counter into a register on the edges they are armed for and can flag an interrupt. All set flags are merged into one interrupt line.

There is no streaming data path, so the block has no valid/ready handshake: every register write takes effect at the clock edge that samples the strobe, and reads are combinational from the address.

Top module: `timer_match_cap`

## Requirements
- R1: After reset every register reads 0 and both `match_o` and `irq_o` are 0.
- R2: The control register (address 0) keeps only bits [1:0]: bit 0 enables counting, bit 1 forces the counter (address 1) and the prescale counter (address 3) to 0 while set; other written bits read back as 0.
- R3: In timer mode the prescale counter runs 0 up to the prescale value (address 2) and wraps to 0; each wrap advances the counter by one, so it steps once every prescale+1 clocks, starting one clock after enabling.
- R4: Match channel n hits when a tick arrives while the counter equals its match value (address 9+n); match flag n (bit n of the flag register, address 7) is set only when bit 3n of the match control register (address 4) is 1.
- R5: When bit 3n+1 of match control is set, the tick that hits channel n loads the counter with 0, giving a period of (match+1)*(prescale+1) clocks.
- R6: When bit 3n+2 of match control is set, a hit on channel n clears control bit 0 and the counter keeps the matched value.
- R7: The output-action register (address 6) holds the pin states in bits [3:0] (driven on `match_o`) and a 2-bit action for channel n at bits [5+2n:4+2n]: 0 keep, 1 drive low, 2 drive high, 3 toggle, applied on each hit.
- R8: Capture channel k (capture control at address 5) copies the counter into its register (address 13+k) on a rising edge of `cap_i[k]` when bit 3k is set and on a falling edge when bit 3k+1 is set; the copy is taken at the third clock edge after the pin changes.
- R9: A capture on channel k sets flag bit 4+k only when capture control bit 3k+2 is set.
- R10: Writing 1 to a bit of the flag register clears that flag; `irq_o` is high exactly while any flag is set.
- R11: Count control (address 8) bits [1:0] select the count source: 0 prescaled ticks, 1 rising, 2 falling, 3 both edges of the pin chosen by bits [3:2] (0 selects `cap_i[0]`, 1 selects `cap_i[1]`).
- R12: Match values are fully writable and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from address |
| cap_i | input | 2 | Capture and count-source pins, asynchronous |
| match_o | output | 4 | Match output pins |
| irq_o | output | 1 | Merged interrupt line |

## Verification
Register writes are seen at the edge after the strobe, the counter moves on the edge where the prescale counter equals its limit (prescale+1 clocks after enabling for the first step), and hits, flags and pin actions all appear at that same tick edge. Capture copies and counted edges land at the third edge after a pin change because of the two-flop synchronizer and edge register, so the bench reads the counter in the cycle it moves the pin and expects that value plus two. All sampling is done half a clock away from the active edge, and periods are measured by counting clocks between consecutive toggles of a match pin.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
  localparam logic [ADDR_W-1:0] A_COUNT    = 4'd1;
  localparam logic [ADDR_W-1:0] A_PRESCALE = 4'd2;
  localparam logic [ADDR_W-1:0] A_PCOUNT   = 4'd3;
  localparam logic [ADDR_W-1:0] A_MCTRL    = 4'd4;
  localparam logic [ADDR_W-1:0] A_CCTRL    = 4'd5;
  localparam logic [ADDR_W-1:0] A_EXTM     = 4'd6;
  localparam logic [ADDR_W-1:0] A_IFLAG    = 4'd7;
  localparam logic [ADDR_W-1:0] A_CNTCTRL  = 4'd8;
  localparam int                A_MATCH0   = 9;

  typedef enum logic [1:0] {
    EXT_KEEP   = 2'd0,
    EXT_LOW    = 2'd1,
    EXT_HIGH   = 2'd2,
    EXT_TOGGLE = 2'd3
  } ext_act_e;

  typedef enum logic [1:0] {
    CM_TIMER = 2'd0,
    CM_RISE  = 2'd1,
    CM_FALL  = 2'd2,
    CM_BOTH  = 2'd3
  } cnt_mode_e;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], din};
  end

  assign rise = shreg[STAGES-1] & ~shreg[STAGES];
  assign fall = ~shreg[STAGES-1] & shreg[STAGES];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         hold,
  input  logic         timer_mode,
  input  logic         ext_edge,
  input  logic [W-1:0] limit,
  output logic [W-1:0] pcount,
  output logic         tick
);
  logic wrap;

  assign wrap = (pcount == limit);
  assign tick = run & ~hold & (timer_mode ? wrap : ext_edge);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pcount <= '0;
    else if (hold || !timer_mode) pcount <= '0;
    else if (run)                pcount <= wrap ? '0 : pcount + W'(1);
  end
endmodule

// File: rtl/tmr_match_ch.sv
module tmr_match_ch
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic     [W-1:0] count,
  input  logic     [W-1:0] mval,
  input  logic             tick,
  input  logic     [2:0]   acts,     // {stop, reset, interrupt}
  input  ext_act_e         ext_sel,
  input  logic             ext_cur,
  output logic             hit,
  output logic             flag_set,
  output logic             want_rst,
  output logic             want_stop,
  output logic             ext_next
);
  assign hit       = tick && (count == mval);
  assign flag_set  = hit & acts[0];
  assign want_rst  = hit & acts[1];
  assign want_stop = hit & acts[2];

  always_comb begin
    ext_next = ext_cur;
    if (hit) begin
      case (ext_sel)
        EXT_LOW:    ext_next = 1'b0;
        EXT_HIGH:   ext_next = 1'b1;
        EXT_TOGGLE: ext_next = ~ext_cur;
        default:    ext_next = ext_cur;
      endcase
    end
  end
endmodule

// File: rtl/timer_match_cap.sv
module timer_match_cap
  import tmr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int N_MATCH = 4,
  parameter int N_CAP   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [N_CAP-1:0]    cap_i,
  output logic [N_MATCH-1:0]  match_o,
  output logic                irq_o
);
  localparam int MC_W     = 3 * N_MATCH;
  localparam int CC_W     = 3 * N_CAP;
  localparam int ACT_W    = 2 * N_MATCH;
  localparam int IF_W     = N_MATCH + N_CAP;
  localparam int CNT_W    = 4;
  localparam int CAP_BASE = A_MATCH0 + N_MATCH;

  // configuration and state
  logic               ctrl_en, ctrl_hold;
  logic [DATA_W-1:0]  prescale, pcount, tc;
  logic [MC_W-1:0]    mctrl;
  logic [CC_W-1:0]    cctrl;
  logic [N_MATCH-1:0] ext_state, ext_next;
  logic [ACT_W-1:0]   ext_act;
  logic [IF_W-1:0]    iflag;
  logic [CNT_W-1:0]   cntctrl;
  logic [DATA_W-1:0]  mval [N_MATCH];
  logic [DATA_W-1:0]  cval [N_CAP];

  // event wiring
  logic [N_CAP-1:0]   rise, fall, cap_ev, cap_set;
  logic [N_MATCH-1:0] m_hit, m_set, m_rst, m_stop;
  logic               any_rst, any_stop, tick, timer_mode, ext_edge;
  logic               src_rise, src_fall;
  cnt_mode_e          mode;

  logic wr_ctrl, wr_pre, wr_mctrl, wr_cctrl, wr_extm, wr_iflag, wr_cnt;
  assign wr_ctrl  = reg_we && (reg_addr == A_CTRL);
  assign wr_pre   = reg_we && (reg_addr == A_PRESCALE);
  assign wr_mctrl = reg_we && (reg_addr == A_MCTRL);
  assign wr_cctrl = reg_we && (reg_addr == A_CCTRL);
  assign wr_extm  = reg_we && (reg_addr == A_EXTM);
  assign wr_iflag = reg_we && (reg_addr == A_IFLAG);
  assign wr_cnt   = reg_we && (reg_addr == A_CNTCTRL);

  // ---------------- pin synchronizers and capture channels ----------------
  for (genvar k = 0; k < N_CAP; k++) begin : g_cap
    tmr_sync_edge #(.STAGES(2)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (cap_i[k]),
      .rise (rise[k]),
      .fall (fall[k])
    );

    assign cap_ev[k]  = (rise[k] & cctrl[3*k]) | (fall[k] & cctrl[3*k+1]);
    assign cap_set[k] = cap_ev[k] & cctrl[3*k+2];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cval[k] <= '0;
      else if (cap_ev[k]) cval[k] <= tc;
    end
  end

  // ---------------- count source selection ----------------
  assign mode       = cnt_mode_e'(cntctrl[1:0]);
  assign timer_mode = (mode == CM_TIMER);

  always_comb begin
    src_rise = 1'b0;
    src_fall = 1'b0;
    for (int k = 0; k < N_CAP; k++) begin
      if (cntctrl[3:2] == 2'(k)) begin
        src_rise = rise[k];
        src_fall = fall[k];
      end
    end
  end

  always_comb begin
    case (mode)
      CM_RISE: ext_edge = src_rise;
      CM_FALL: ext_edge = src_fall;
      CM_BOTH: ext_edge = src_rise | src_fall;
      default: ext_edge = 1'b0;
    endcase
  end

  tmr_prescaler #(.W(DATA_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (ctrl_en),
    .hold      (ctrl_hold),
    .timer_mode(timer_mode),
    .ext_edge  (ext_edge),
    .limit     (prescale),
    .pcount    (pcount),
    .tick      (tick)
  );

  // ---------------- match channels ----------------
  for (genvar n = 0; n < N_MATCH; n++) begin : g_match
    tmr_match_ch #(.W(DATA_W)) u_ch (
      .count    (tc),
      .mval     (mval[n]),
      .tick     (tick),
      .acts     (mctrl[3*n +: 3]),
      .ext_sel  (ext_act_e'(ext_act[2*n +: 2])),
      .ext_cur  (ext_state[n]),
      .hit      (m_hit[n]),
      .flag_set (m_set[n]),
      .want_rst (m_rst[n]),
      .want_stop(m_stop[n]),
      .ext_next (ext_next[n])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mval[n] <= '0;
      else if (reg_we && (reg_addr == ADDR_W'(A_MATCH0 + n))) mval[n] <= reg_wdata;
    end
  end

  assign any_rst  = |m_rst;
  assign any_stop = |m_stop;

  // ---------------- timer counter and control ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tc <= '0;
    else if (ctrl_hold) tc <= '0;
    else if (tick) begin
      if (any_rst)       tc <= '0;
      else if (any_stop) tc <= tc;
      else               tc <= tc + DATA_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      ctrl_hold <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl_en   <= reg_wdata[0];
      ctrl_hold <= reg_wdata[1];
    end else if (any_stop) begin
      ctrl_en   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prescale <= '0;
      mctrl    <= '0;
      cctrl    <= '0;
      cntctrl  <= '0;
    end else begin
      if (wr_pre)   prescale <= reg_wdata;
      if (wr_mctrl) mctrl    <= reg_wdata[MC_W-1:0];
      if (wr_cctrl) cctrl    <= reg_wdata[CC_W-1:0];
      if (wr_cnt)   cntctrl  <= reg_wdata[CNT_W-1:0];
    end
  end

  // output pin states: a register write overrides a hit in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_state <= '0;
      ext_act   <= '0;
    end else if (wr_extm) begin
      ext_state <= reg_wdata[N_MATCH-1:0];
      ext_act   <= reg_wdata[N_MATCH +: ACT_W];
    end else begin
      ext_state <= ext_next;
    end
  end

  // flags: a new event wins over a write-one-to-clear in the same cycle
  logic [IF_W-1:0] flag_clr;
  assign flag_clr = wr_iflag ? reg_wdata[IF_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) iflag <= '0;
    else        iflag <= (iflag & ~flag_clr) | {cap_set, m_set};
  end

  assign irq_o   = |iflag;
  assign match_o = ext_state;

  // ---------------- read mux ----------------
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:     reg_rdata = DATA_W'({ctrl_hold, ctrl_en});
      A_COUNT:    reg_rdata = tc;
      A_PRESCALE: reg_rdata = prescale;
      A_PCOUNT:   reg_rdata = pcount;
      A_MCTRL:    reg_rdata = DATA_W'(mctrl);
      A_CCTRL:    reg_rdata = DATA_W'(cctrl);
      A_EXTM:     reg_rdata = DATA_W'({ext_act, ext_state});
      A_IFLAG:    reg_rdata = DATA_W'(iflag);
      A_CNTCTRL:  reg_rdata = DATA_W'(cntctrl);
      default:    reg_rdata = '0;
    endcase
    for (int n = 0; n < N_MATCH; n++)
      if (reg_addr == ADDR_W'(A_MATCH0 + n)) reg_rdata = mval[n];
    for (int k = 0; k < N_CAP; k++)
      if (reg_addr == ADDR_W'(CAP_BASE + k)) reg_rdata = cval[k];
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int N_MATCH = 4,
  parameter int N_CAP   = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reg_we,
  input logic [ADDR_W-1:0]      reg_addr,
  input logic                   ctrl_en,
  input logic                   ctrl_hold,
  input logic                   timer_mode,
  input logic                   any_stop,
  input logic [DATA_W-1:0]      tc,
  input logic [DATA_W-1:0]      pcount,
  input logic [DATA_W-1:0]      prescale,
  input logic [N_MATCH+N_CAP-1:0] iflag,
  input logic [3*N_CAP-1:0]     cctrl
);
  AST_HOLD_ZEROES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hold |=> (tc == '0)); // R2

  AST_COUNT_WAITS_FOR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && !ctrl_hold && timer_mode && (pcount != prescale)) |=> $stable(tc)); // R3

  AST_COUNT_STEP_OR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tc) |-> ((tc == $past(tc) + DATA_W'(1)) || (tc == '0))); // R5

  AST_STOP_DROPS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (any_stop && !(reg_we && (reg_addr == A_CTRL))) |=> !ctrl_en); // R6

  AST_CAP_FLAG_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iflag[N_MATCH]) |-> $past(cctrl[2])); // R9
endmodule

bind timer_match_cap tmr_checker #(
  .DATA_W (DATA_W),
  .N_MATCH(N_MATCH),
  .N_CAP  (N_CAP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .ctrl_en   (ctrl_en),
  .ctrl_hold (ctrl_hold),
  .timer_mode(timer_mode),
  .any_stop  (any_stop),
  .tc        (tc),
  .pcount    (pcount),
  .prescale  (prescale),
  .iflag     (iflag),
  .cctrl     (cctrl)
);

// File: tb/timer_match_cap_test.sv
module timer_match_cap_test;
  localparam logic [3:0] CTRL = 0, COUNT = 1, PRESC = 2, PCNT = 3, MCTL = 4,
                         CCTL = 5, EXTM = 6, FLAGS = 7, CNTC = 8, MATCH0 = 9,
                         CAP0 = 13;
  localparam int NV = 5;
  // prescale, match value, expected period in clocks
  localparam int unsigned VP[NV] = '{0, 0, 1, 4, 2};
  localparam int unsigned VM[NV] = '{0, 3, 2, 1, 4};
  localparam int unsigned VE[NV] = '{1, 4, 6, 10, 15};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  cap = '0;
  logic [3:0]  mo;
  logic        irq;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  timer_match_cap uut (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .cap_i(cap), .match_o(mo), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic pulses(input int pin, input int cnt);
    for (int i = 0; i < cnt; i++) begin
      cap[pin] = 1'b1; repeat (4) @(negedge clk);
      cap[pin] = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, t;
    int cnt;
    logic prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(CTRL, v);  check("R1 ctrl", v, 0);
    rd(COUNT, v); check("R1 count", v, 0);
    rd(FLAGS, v); check("R1 flags", v, 0);
    check("R1 match_o", 32'(mo), 0);
    check("R1 irq", 32'(irq), 0);

    // R12 match value round trip
    wr(MATCH0 + 4'd2, 32'hDEADBEEF);
    rd(MATCH0 + 4'd2, v); check("R12 match2", v, 32'hDEADBEEF);
    wr(MATCH0 + 4'd2, 0);

    // R2 control bits
    wr(CTRL, 32'hFFFF_FFFF);
    rd(CTRL, v); check("R2 ctrl mask", v, 3);
    repeat (5) @(negedge clk);
    rd(COUNT, v); check("R2 hold keeps zero", v, 0);
    wr(CTRL, 32'hFFFF_FFFE);
    rd(CTRL, v); check("R2 ctrl mask b", v, 2);

    // R3 prescaled timing
    wr(PRESC, 2);
    wr(CTRL, 1);
    rd(COUNT, v); check("R3 count start", v, 0);
    repeat (9) @(negedge clk);
    rd(COUNT, v); check("R3 count after 9", v, 3);
    rd(PCNT, v);  check("R3 pcount wrapped", v, 0);
    repeat (2) @(negedge clk);
    rd(PCNT, v);  check("R3 pcount 2", v, 2);
    rd(COUNT, v); check("R3 count held", v, 3);

    // R5 period table: reset on match 0, toggle pin 0, no interrupt bit
    for (int i = 0; i < NV; i++) begin
      wr(CTRL, 2);
      wr(PRESC, VP[i]);
      wr(MATCH0, VM[i]);
      wr(MCTL, 32'h2);
      wr(EXTM, 32'h30);
      wr(CTRL, 1);
      prev = mo[0]; cnt = 0;
      while (mo[0] == prev) begin @(negedge clk); cnt++; end
      prev = mo[0]; cnt = 0;
      while (mo[0] == prev) begin @(negedge clk); cnt++; end
      check($sformatf("R5 period entry %0d", i), 32'(cnt), VE[i]);
    end
    rd(FLAGS, v); check("R4 no flag without enable", v, 0);

    // R6 stop on match channel 1 with interrupt
    wr(CTRL, 2);
    wr(PRESC, 0);
    wr(EXTM, 0);
    wr(MATCH0 + 4'd1, 4);
    wr(MCTL, 32'h28);
    wr(CTRL, 1);
    repeat (10) @(negedge clk);
    rd(COUNT, v); check("R6 count stays", v, 4);
    rd(CTRL, v);  check("R6 enable cleared", v, 0);
    rd(FLAGS, v); check("R4 match1 flag", v, 32'h2);
    check("R10 irq high", 32'(irq), 1);
    wr(FLAGS, 32'h2);
    rd(FLAGS, v); check("R10 flag cleared", v, 0);
    check("R10 irq low", 32'(irq), 0);

    // R7 pin actions: low, high, toggle, keep on channels 0..3
    wr(CTRL, 2);
    for (int n = 0; n < 4; n++) wr(MATCH0 + 4'(n), 2);
    wr(MCTL, 32'h4);
    wr(EXTM, 32'h395);
    check("R7 initial pins", 32'(mo), 32'h5);
    wr(CTRL, 1);
    repeat (6) @(negedge clk);
    check("R7 pins after hit", 32'(mo), 32'h2);
    rd(EXTM, v); check("R7 register", v, 32'h392);

    // R8/R9 capture channels
    wr(CTRL, 2);
    wr(MCTL, 0);
    wr(EXTM, 0);
    wr(CCTL, 32'h15);
    wr(CTRL, 1);
    repeat (3) @(negedge clk);
    rd(COUNT, t); cap[0] = 1'b1;
    repeat (4) @(negedge clk);
    rd(CAP0, v);  check("R8 rising capture", v, t + 2);
    rd(FLAGS, v); check("R9 cap0 flag", v, 32'h10);
    cap[1] = 1'b1;
    repeat (5) @(negedge clk);
    rd(CAP0 + 4'd1, v); check("R8 rise ignored on ch1", v, 0);
    rd(COUNT, t); cap[1] = 1'b0;
    repeat (4) @(negedge clk);
    rd(CAP0 + 4'd1, v); check("R8 falling capture", v, t + 2);
    rd(FLAGS, v); check("R9 no cap1 flag", v, 32'h10);
    wr(FLAGS, 32'h10);
    rd(FLAGS, v); check("R10 cap flag cleared", v, 0);
    check("R10 irq low after cap", 32'(irq), 0);

    // R11 counter modes
    wr(CTRL, 2);
    wr(CCTL, 0);
    cap = 2'b00;
    repeat (5) @(negedge clk);
    wr(CNTC, 32'h6);
    wr(CTRL, 1);
    pulses(1, 3);
    repeat (4) @(negedge clk);
    rd(COUNT, v); check("R11 falling on pin1", v, 3);
    wr(CTRL, 2);
    wr(CNTC, 32'h3);
    wr(CTRL, 1);
    pulses(0, 3);
    repeat (4) @(negedge clk);
    rd(COUNT, v); check("R11 both edges on pin0", v, 6);
    wr(CTRL, 2);
    wr(CNTC, 32'h1);
    wr(CTRL, 1);
    pulses(1, 2);
    repeat (4) @(negedge clk);
    rd(COUNT, v); check("R11 other pin ignored", v, 0);

    finish_run();
  end
endmodule